// File: doc/BRIEF.md
# Dual-Operand Accumulator ALU Core

This block is the arithmetic and logic datapath of a small eight-bit processor. Two hidden operand registers, here called the primary operand W and the secondary operand Z, capture values from a shared input bus under separate load strobes. Neither register can place its value back on that bus. Both register outputs feed an adder/subtractor and a bank of bitwise units at all times. A one-hot select from the sequencer decides which unit's result appears on the result port. A four-bit flag register is written on request from the adder's carry logic, the selected result and the sign bits of the operands.

No path is dedicated to increment, decrement, borrow arithmetic or temporary storage. The sequencer clears Z and steers the carry-in instead. In subtract mode the block adds the one's complement of Z, inverts the selected carry-in on its way into the adder, and inverts the carry-out on its way to the flags. The carry flag therefore holds a borrow after a subtraction. Adding with Z cleared and no carry passes W through unchanged, which lets the sequencer use W as a scratch register.

Top module: `dual_opnd_alu`

## Requirements
- R1: After reset W is 0x00. On a rising clock edge with `ld_w` high, W takes `bus_in`. With `ld_w` low, W keeps its value whatever `bus_in` does.
- R2: After reset Z is 0x00. On a rising edge with `ld_z` high, Z takes `bus_in`. With `clr_z` high, Z becomes 0x00 on that edge, and this wins over `ld_z`.
- R3: The raw carry-in is 1 when `cin_force` is high. Otherwise it is the stored carry flag when `cin_use_flag` is high, and 0 when neither is high. With `sub_mode` high the adder adds the bitwise complement of Z plus the inverse of the raw carry-in.
- R4: With `sub_mode` low the sum output is (W + Z + raw carry-in) mod 256. With `sub_mode` high it is (W − Z − raw carry-in) mod 256.
- R5: The carry candidate is the adder's carry-out XORed with `sub_mode`: a carry after an addition and a borrow after a subtraction. With `carry_from_cin` high, the flag write takes the raw carry-in instead.
- R6: With Z cleared, an addition with `cin_force` gives W+1, a subtraction with `cin_force` gives W−1, and an addition with no carry source returns W unchanged.
- R7: The bitwise units continuously give W AND Z, W OR Z and W XOR Z.
- R8: `out_sel` is one-hot, with bit 0 = sum, bit 1 = AND, bit 2 = OR and bit 3 = XOR. The enabled unit drives `res_out` and `res_valid` is high. With no bit set, `res_out` is 0x00 and `res_valid` is low.
- R9: `flags_q` is {carry, zero, negative, overflow} on bits [3:0]. It resets to 0000 and changes only on a rising edge with `flags_we` high.
- R10: On a flag write, zero is set when `res_out` is 0x00 and negative takes bit 7 of the sum. Overflow is set when the adder's two effective operands share a sign that differs from the sign of the sum. It is computed from the XOR of the two operand MSBs, the W MSB and the sum MSB.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_in | input | 8 | Shared input bus feeding both operand registers |
| ld_w | input | 1 | Load W from the bus |
| ld_z | input | 1 | Load Z from the bus |
| clr_z | input | 1 | Synchronous clear of Z, takes priority over the load |
| sub_mode | input | 1 | Subtract: complement Z, invert carry-in and carry-out |
| cin_use_flag | input | 1 | Raw carry-in taken from the stored carry flag |
| cin_force | input | 1 | Raw carry-in forced to 1 |
| carry_from_cin | input | 1 | Carry flag write takes the raw carry-in instead of the carry-out |
| out_sel | input | 4 | One-hot result select: sum, AND, OR, XOR |
| flags_we | input | 1 | Write the flag register on this edge |
| res_out | output | 8 | Selected unit result, 0x00 when nothing is selected |
| res_valid | output | 1 | High when a unit is selected |
| flags_q | output | 4 | Flags {carry, zero, negative, overflow} |

## Verification
A wrong value in W or Z shows at `res_out` in the same cycle that any unit is selected. The bench reads it back by clearing Z and selecting the sum, or by ANDing against an all-ones W, so a lost or spurious load appears one edge after the strobe. A wrong carry-conditioning inversion gives a sum off by one and a carry flag of the wrong sense on the edge after `flags_we`. A wrong flag register shows at the next operation that reads the carry back through `cin_use_flag`. Flags that change without a write, or miss one, show one edge after the operation.

// File: rtl/dual_opnd_alu_pkg.sv
package dual_opnd_alu_pkg;
   // result select positions, fixed by the one-hot out_sel encoding
   localparam int IDX_SUM = 0;
   localparam int IDX_AND = 1;
   localparam int IDX_OR  = 2;
   localparam int IDX_XOR = 3;
   localparam int NUM_SEL = 4;

   typedef struct packed {
      logic c;
      logic z;
      logic n;
      logic v;
   } alu_flags_t;
endpackage

// File: rtl/opnd_reg.sv
module opnd_reg #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ld,
   input  logic              clr,
   input  logic [DATA_W-1:0] d,
   output logic [DATA_W-1:0] q
);
   if (DATA_W < 2) begin : g_bad_w
      $error("opnd_reg: DATA_W must be at least 2");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   q <= '0;
      else if (clr) q <= '0;
      else if (ld)  q <= d;
   end
endmodule

// File: rtl/addsub_unit.sv
module addsub_unit #(
   parameter int DATA_W = 8,
   parameter bit RIPPLE = 1'b0
) (
   input  logic [DATA_W-1:0] a,
   input  logic [DATA_W-1:0] b,
   input  logic              sub,
   input  logic              raw_cin,
   output logic [DATA_W-1:0] sum,
   output logic              cout_cond
);
   logic [DATA_W-1:0] b_eff;
   logic              cin_eff;
   logic              cout_raw;

   assign b_eff   = b ^ {DATA_W{sub}};
   assign cin_eff = raw_cin ^ sub;

   if (RIPPLE) begin : g_ripple
      logic [DATA_W:0] cy;
      assign cy[0] = cin_eff;
      for (genvar i = 0; i < DATA_W; i++) begin : g_bit
         assign sum[i]  = a[i] ^ b_eff[i] ^ cy[i];
         assign cy[i+1] = (a[i] & b_eff[i]) | (cy[i] & (a[i] ^ b_eff[i]));
      end
      assign cout_raw = cy[DATA_W];
   end else begin : g_flat
      logic [DATA_W:0] wide;
      assign wide     = {1'b0, a} + {1'b0, b_eff} + {{DATA_W{1'b0}}, cin_eff};
      assign sum      = wide[DATA_W-1:0];
      assign cout_raw = wide[DATA_W];
   end

   assign cout_cond = cout_raw ^ sub;
endmodule

// File: rtl/bitwise_unit.sv
module bitwise_unit #(
   parameter int DATA_W = 8
) (
   input  logic [DATA_W-1:0] a,
   input  logic [DATA_W-1:0] b,
   output logic [DATA_W-1:0] and_o,
   output logic [DATA_W-1:0] or_o,
   output logic [DATA_W-1:0] xor_o
);
   for (genvar i = 0; i < DATA_W; i++) begin : g_bit
      assign and_o[i] = a[i] & b[i];
      assign or_o[i]  = a[i] | b[i];
      assign xor_o[i] = a[i] ^ b[i];
   end
endmodule

// File: rtl/flag_unit.sv
module flag_unit
   import dual_opnd_alu_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic              carry_from_cin,
   input  logic              raw_cin,
   input  logic              cout_cond,
   input  logic              sub,
   input  logic [DATA_W-1:0] result,
   input  logic              sum_msb,
   input  logic              w_msb,
   input  logic              xor_msb,
   output alu_flags_t        flags
);
   alu_flags_t nxt;

   always_comb begin
      nxt.c = carry_from_cin ? raw_cin : cout_cond;
      nxt.z = (result == '0);
      nxt.n = sum_msb;
      // effective operand signs agree when the raw MSB xor matches the mode
      nxt.v = ~(xor_msb ^ sub) & (sum_msb ^ w_msb);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  flags <= '0;
      else if (we) flags <= nxt;
   end
endmodule

// File: rtl/dual_opnd_alu.sv
module dual_opnd_alu
   import dual_opnd_alu_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter bit RIPPLE = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] bus_in,
   input  logic              ld_w,
   input  logic              ld_z,
   input  logic              clr_z,
   input  logic              sub_mode,
   input  logic              cin_use_flag,
   input  logic              cin_force,
   input  logic              carry_from_cin,
   input  logic [3:0]        out_sel,
   input  logic              flags_we,
   output logic [DATA_W-1:0] res_out,
   output logic              res_valid,
   output logic [3:0]        flags_q
);
   localparam int MSB = DATA_W - 1;

   if (NUM_SEL != 4) begin : g_bad_sel
      $error("dual_opnd_alu: select width mismatch");
   end

   logic [DATA_W-1:0] w_q, z_q;
   logic [DATA_W-1:0] sum, and_r, or_r, xor_r;
   logic              cout_cond, raw_cin;
   alu_flags_t        flags;
   logic [DATA_W-1:0] unit_res [NUM_SEL];
   logic [DATA_W-1:0] masked   [NUM_SEL];

   opnd_reg #(.DATA_W(DATA_W)) u_w (
      .clk(clk), .rst_n(rst_n), .ld(ld_w), .clr(1'b0), .d(bus_in), .q(w_q)
   );
   opnd_reg #(.DATA_W(DATA_W)) u_z (
      .clk(clk), .rst_n(rst_n), .ld(ld_z), .clr(clr_z), .d(bus_in), .q(z_q)
   );

   assign raw_cin = cin_force | (cin_use_flag & flags.c);

   addsub_unit #(.DATA_W(DATA_W), .RIPPLE(RIPPLE)) u_add (
      .a(w_q), .b(z_q), .sub(sub_mode), .raw_cin(raw_cin),
      .sum(sum), .cout_cond(cout_cond)
   );

   bitwise_unit #(.DATA_W(DATA_W)) u_bit (
      .a(w_q), .b(z_q), .and_o(and_r), .or_o(or_r), .xor_o(xor_r)
   );

   assign unit_res[IDX_SUM] = sum;
   assign unit_res[IDX_AND] = and_r;
   assign unit_res[IDX_OR]  = or_r;
   assign unit_res[IDX_XOR] = xor_r;

   for (genvar k = 0; k < NUM_SEL; k++) begin : g_mask
      assign masked[k] = unit_res[k] & {DATA_W{out_sel[k]}};
   end

   always_comb begin
      res_out = '0;
      for (int k = 0; k < NUM_SEL; k++) res_out = res_out | masked[k];
   end
   assign res_valid = |out_sel;

   flag_unit #(.DATA_W(DATA_W)) u_flg (
      .clk(clk), .rst_n(rst_n), .we(flags_we), .carry_from_cin(carry_from_cin),
      .raw_cin(raw_cin), .cout_cond(cout_cond), .sub(sub_mode),
      .result(res_out), .sum_msb(sum[MSB]), .w_msb(w_q[MSB]),
      .xor_msb(xor_r[MSB]), .flags(flags)
   );

   assign flags_q = flags;
endmodule

// File: rtl/dual_opnd_alu_chk.sv
module dual_opnd_alu_chk #(
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              ld_w,
   input logic              ld_z,
   input logic              clr_z,
   input logic [DATA_W-1:0] bus_in,
   input logic [DATA_W-1:0] w_q,
   input logic [DATA_W-1:0] z_q,
   input logic [3:0]        out_sel,
   input logic [DATA_W-1:0] res_out,
   input logic              res_valid,
   input logic              flags_we,
   input logic [3:0]        flags_q
);
   AST_W_LOAD: assert property (@(posedge clk) disable iff (!rst_n) ld_w |=> w_q == $past(bus_in)); // R1
   AST_W_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !ld_w |=> w_q == $past(w_q)); // R1
   AST_Z_CLEAR: assert property (@(posedge clk) disable iff (!rst_n) clr_z |=> z_q == '0); // R2
   AST_Z_LOAD: assert property (@(posedge clk) disable iff (!rst_n) (ld_z && !clr_z) |=> z_q == $past(bus_in)); // R2
   AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(out_sel)); // R8
   AST_IDLE_BUS: assert property (@(posedge clk) disable iff (!rst_n) (out_sel == 4'b0) |-> (res_out == '0 && !res_valid)); // R8
   AST_FLAGS_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !flags_we |=> flags_q == $past(flags_q)); // R9
   AST_ZERO_FLAG: assert property (@(posedge clk) disable iff (!rst_n) flags_we |=> flags_q[2] == ($past(res_out) == '0)); // R10
endmodule

bind dual_opnd_alu dual_opnd_alu_chk #(.DATA_W(DATA_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .ld_w(ld_w), .ld_z(ld_z), .clr_z(clr_z),
   .bus_in(bus_in), .w_q(w_q), .z_q(z_q), .out_sel(out_sel),
   .res_out(res_out), .res_valid(res_valid), .flags_we(flags_we),
   .flags_q(flags_q)
);

// File: tb/sim_dual_opnd_alu.sv
`timescale 1ns/1ps
module sim_dual_opnd_alu;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] bus_in = '0;
   logic       ld_w = 0, ld_z = 0, clr_z = 0;
   logic       sub_mode = 0, cin_use_flag = 0, cin_force = 0, carry_from_cin = 0;
   logic [3:0] out_sel = '0;
   logic       flags_we = 0;
   logic [7:0] res_out;
   logic       res_valid;
   logic [3:0] flags_q;

   int  n_chk = 0, n_fail = 0;
   bit  done = 0;
   logic [7:0] wm = '0, zm = '0;
   logic [3:0] fm = '0;

   always #2.5 clk = ~clk;

   dual_opnd_alu u0 (
      .clk(clk), .rst_n(rst_n), .bus_in(bus_in), .ld_w(ld_w), .ld_z(ld_z),
      .clr_z(clr_z), .sub_mode(sub_mode), .cin_use_flag(cin_use_flag),
      .cin_force(cin_force), .carry_from_cin(carry_from_cin),
      .out_sel(out_sel), .flags_we(flags_we), .res_out(res_out),
      .res_valid(res_valid), .flags_q(flags_q)
   );

   task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   // returns {overflow, 9-bit wrapped result whose bit 8 is carry/borrow}
   function automatic logic [9:0] model(logic [7:0] w, logic [7:0] z, logic sub, logic rc);
      logic [8:0] t;
      int sv;
      if (sub) begin
         t  = {1'b0, w} - {1'b0, z} - {8'b0, rc};
         sv = int'($signed(w)) - int'($signed(z)) - int'(rc);
      end else begin
         t  = {1'b0, w} + {1'b0, z} + {8'b0, rc};
         sv = int'($signed(w)) + int'($signed(z)) + int'(rc);
      end
      return {(sv > 127 || sv < -128), t};
   endfunction

   task automatic load_w(logic [7:0] v);
      @(negedge clk); bus_in = v; ld_w = 1;
      @(negedge clk); ld_w = 0; wm = v;
   endtask

   task automatic load_z(logic [7:0] v);
      @(negedge clk); bus_in = v; ld_z = 1;
      @(negedge clk); ld_z = 0; zm = v;
   endtask

   task automatic clear_z();
      @(negedge clk); clr_z = 1;
      @(negedge clk); clr_z = 0; zm = '0;
   endtask

   // sum select; result checked before the edge, flags after it
   task automatic arith(string req, logic sub, logic use_c, logic force_c, logic csrc, logic we);
      logic rc;
      logic [9:0] m;
      logic [3:0] ef;
      rc = force_c ? 1'b1 : (use_c ? fm[3] : 1'b0);
      m  = model(wm, zm, sub, rc);
      ef = {(csrc ? rc : m[8]), (m[7:0] == 8'h00), m[7], m[9]};
      @(negedge clk);
      sub_mode = sub; cin_use_flag = use_c; cin_force = force_c;
      carry_from_cin = csrc; out_sel = 4'b0001; flags_we = we;
      #1;
      chk(req, "sum", {24'b0, res_out}, {24'b0, m[7:0]});
      chk("R8", "valid", {31'b0, res_valid}, 32'd1);
      @(negedge clk);
      sub_mode = 0; cin_use_flag = 0; cin_force = 0; carry_from_cin = 0;
      out_sel = '0; flags_we = 0;
      if (we) fm = ef;
      chk(we ? req : "R9", "flags", {28'b0, flags_q}, {28'b0, fm});
   endtask

   task automatic logic_op(string req, logic [3:0] sel, logic we);
      logic [7:0] er;
      logic [9:0] m;
      er = sel[1] ? (wm & zm) : sel[2] ? (wm | zm) : (wm ^ zm);
      m  = model(wm, zm, 1'b0, 1'b0);
      @(negedge clk); out_sel = sel; flags_we = we;
      #1;
      chk(req, "logic", {24'b0, res_out}, {24'b0, er});
      @(negedge clk); out_sel = '0; flags_we = 0;
      if (we) fm = {m[8], (er == 8'h00), m[7], m[9]};
      chk("R10", "logic flags", {28'b0, flags_q}, {28'b0, fm});
   endtask

   task automatic t_reset();
      #1;
      chk("R8", "reset res", {24'b0, res_out}, 32'h0);
      chk("R9", "reset flags", {28'b0, flags_q}, 32'h0);
      // W and Z both zero: sum and OR of reset registers
      logic_op("R1", 4'b0100, 1'b0);
      arith("R2", 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
   endtask

   task automatic t_add();
      load_w(8'h35); load_z(8'h4A);
      arith("R4", 0, 0, 0, 0, 1);            // 0x7F, no flags
      load_w(8'h70); load_z(8'h20);
      arith("R10", 0, 0, 0, 0, 1);           // 0x90 overflow, negative
      load_w(8'hF0);
      arith("R5", 0, 0, 0, 0, 1);            // 0x10 with carry
   endtask

   task automatic t_sub();
      load_w(8'h50); load_z(8'h20);
      arith("R4", 1, 0, 0, 0, 1);            // 0x30, no borrow
      load_w(8'h20); load_z(8'h50);
      arith("R5", 1, 0, 0, 0, 1);            // 0xD0, borrow set
      load_w(8'h80); load_z(8'h01);
      arith("R10", 1, 0, 0, 0, 1);           // 0x7F signed overflow
   endtask

   task automatic t_carry_chain();
      load_w(8'h20); load_z(8'h50);
      arith("R5", 1, 0, 0, 0, 1);            // leaves borrow = 1
      load_w(8'h01); load_z(8'h01);
      arith("R3", 0, 1, 0, 0, 1);            // 1+1+C = 3
      load_w(8'h10); load_z(8'h01);
      arith("R3", 1, 0, 1, 0, 1);            // 0x10-1-1 = 0x0E
   endtask

   task automatic t_incdec();
      load_w(8'hFF); clear_z();
      arith("R6", 0, 0, 1, 0, 1);            // inc 0xFF -> 0x00, C=1, Z=1
      load_w(8'h00);
      arith("R6", 1, 0, 1, 0, 1);            // dec 0x00 -> 0xFF, borrow
      load_w(8'hA7);
      arith("R6", 0, 0, 0, 0, 0);            // pass-through of W
   endtask

   task automatic t_logic();
      load_w(8'hC3); load_z(8'h5A);
      logic_op("R7", 4'b0010, 1);
      logic_op("R7", 4'b0100, 1);
      logic_op("R7", 4'b1000, 1);
      load_z(8'h3C);
      logic_op("R10", 4'b0010, 1);           // AND gives 0x00 -> zero flag
   endtask

   task automatic t_idle();
      @(negedge clk); out_sel = '0; #1;
      chk("R8", "idle res", {24'b0, res_out}, 32'h0);
      chk("R8", "idle valid", {31'b0, res_valid}, 32'h0);
   endtask

   task automatic t_hold();
      load_w(8'h20); load_z(8'h50);
      arith("R9", 1, 0, 0, 0, 0);            // no write: flags stay
      @(negedge clk); bus_in = 8'hAA;       // ld_w low over an edge
      @(negedge clk);
      clear_z();
      arith("R1", 0, 0, 0, 0, 0);            // W still 0x20
   endtask

   task automatic t_clr_prio();
      load_w(8'hFF);
      @(negedge clk); bus_in = 8'h55; ld_z = 1; clr_z = 1;
      @(negedge clk); ld_z = 0; clr_z = 0; zm = 8'h00;
      logic_op("R2", 4'b0010, 0);            // AND with 0xFF exposes Z
   endtask

   task automatic t_carry_src();
      load_w(8'h01); load_z(8'h01);
      arith("R5", 0, 0, 1, 1, 1);            // carry flag takes forced cin
      arith("R5", 0, 0, 0, 1, 1);            // carry flag takes cin 0
   endtask

   initial begin
      #10000;
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      t_reset();
      t_add();
      t_sub();
      t_carry_chain();
      t_incdec();
      t_logic();
      t_idle();
      t_hold();
      t_clr_prio();
      t_carry_src();
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule